// File: doc/BRIEF.md
# Upward-Growing Hardware Stack Unit

This block is the stack engine of a small 8-bit controller. It keeps an 8-bit stack pointer and a 128-byte internal data RAM in which the stack lives. A push strobe stores a byte and a pop strobe returns the most recently stored byte. The pointer moves toward higher addresses on a push and toward lower addresses on a pop, so the stack can grow through the whole RAM.

Software can move the stack at any time through a direct pointer-load port, and it can read the pointer back continuously. Two one-cycle flags report a push that would run past the RAM top and a pop from an empty pointer. Simultaneous push and pop is treated as no operation. A pointer load in the same cycle as either strobe wins over it.

Top module: `stk_engine`

## Requirements
- R1: After reset the pointer output reads 07h, both flags are low and the data output is 00h.
- R2: A push with pointer below 7Fh first adds one to the pointer and then stores the input byte at the new pointer value, so the first push after reset stores at 08h. The new pointer is visible one cycle after the push.
- R3: A push with pointer at or above 7Fh stores nothing and leaves the pointer unchanged. The overflow flag is high for exactly the one cycle after that push.
- R4: A pop with a nonzero pointer puts the byte stored at the pointer on the data output and subtracts one from the pointer, both one cycle after the pop. Otherwise the data output holds its value.
- R5: A pop with pointer 00h leaves the pointer and the data output unchanged. The underflow flag is high for exactly the one cycle after that pop.
- R6: A pointer load sets the pointer to the load value one cycle later, whatever the push and pop strobes are. A byte presented with a push in that cycle is not stored, and neither flag rises.
- R7: Push and pop asserted together, with no load, leave the pointer, the data output, the RAM contents and both flags unchanged.
- R8: RAM is addressed by the low 7 bits of the pointer, so a pop with a loaded pointer above 7Fh returns the byte at the pointer modulo 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| din_i | input | 8 | Byte to push |
| ptr_load_i | input | 1 | Direct pointer load strobe |
| ptr_val_i | input | 8 | Pointer load value |
| dout_o | output | 8 | Last popped byte, registered |
| sp_o | output | 8 | Current stack pointer |
| ovf_o | output | 1 | One-cycle push overflow flag |
| unf_o | output | 1 | One-cycle pop underflow flag |

## Verification
A pointer that is off by one shows on `sp_o` in the very next cycle. It also pairs every later pop with the wrong RAM byte, so `dout_o` is wrong from the first pop after the fault. A write that goes to the wrong address, or that should have been blocked, stays hidden until that location is popped. For this reason the bench fills the whole RAM first and then pops across all of it. A flag stuck or asserted late is visible one cycle after the offending strobe, because each flag is a single-cycle pulse.

// File: rtl/stk_pkg.sv
package stk_pkg;
   typedef enum logic [1:0] {
      STK_NONE = 2'd0,
      STK_PUSH = 2'd1,
      STK_POP  = 2'd2,
      STK_LOAD = 2'd3
   } stk_op_e;
endpackage

// File: rtl/stk_op_decode.sv
module stk_op_decode
   import stk_pkg::*;
(
   input  logic    push_i,
   input  logic    pop_i,
   input  logic    load_i,
   output stk_op_e op_o
);
   always_comb begin
      if (load_i)                op_o = STK_LOAD;
      else if (push_i && !pop_i) op_o = STK_PUSH;
      else if (pop_i && !push_i) op_o = STK_POP;
      else                       op_o = STK_NONE;
   end
endmodule

// File: rtl/stk_ptr_ctrl.sv
module stk_ptr_ctrl
   import stk_pkg::*;
#(
   parameter int PTR_W     = 8,
   parameter int RAM_DEPTH = 128,
   parameter int RESET_PTR = 7,
   localparam int ADDR_W   = $clog2(RAM_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  stk_op_e           op_i,
   input  logic [PTR_W-1:0]  load_val_i,
   output logic [PTR_W-1:0]  sp_o,
   output logic              ovf_o,
   output logic              unf_o,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic              rd_en_o,
   output logic [ADDR_W-1:0] rd_addr_o
);
   localparam logic [PTR_W-1:0] TOP = PTR_W'(RAM_DEPTH - 1);

   generate
      if (ADDR_W > PTR_W) begin : g_bad_width
         $error("stk_ptr_ctrl: pointer narrower than RAM address");
      end
      if (RESET_PTR >= RAM_DEPTH) begin : g_bad_reset
         $error("stk_ptr_ctrl: reset pointer outside RAM");
      end
   endgenerate

   logic [PTR_W-1:0] sp_q, sp_inc, sp_dec;
   logic             full, empty;

   assign sp_inc    = sp_q + 1'b1;
   assign sp_dec    = sp_q - 1'b1;
   assign full      = (sp_q >= TOP);
   assign empty     = (sp_q == '0);
   assign wr_en_o   = (op_i == STK_PUSH) && !full;
   assign wr_addr_o = sp_inc[ADDR_W-1:0];
   assign rd_en_o   = (op_i == STK_POP) && !empty;
   assign rd_addr_o = sp_q[ADDR_W-1:0];
   assign sp_o      = sp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q  <= PTR_W'(RESET_PTR);
         ovf_o <= 1'b0;
         unf_o <= 1'b0;
      end else begin
         ovf_o <= (op_i == STK_PUSH) && full;
         unf_o <= (op_i == STK_POP) && empty;
         case (op_i)
            STK_LOAD: sp_q <= load_val_i;
            STK_PUSH: if (!full)  sp_q <= sp_inc;
            STK_POP:  if (!empty) sp_q <= sp_dec;
            default:  sp_q <= sp_q;
         endcase
      end
   end

   assert_push_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == STK_PUSH && sp_q < TOP) |=> sp_q == $past(sp_q) + 1'b1);
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == STK_PUSH && sp_q >= TOP) |=> (ovf_o && $stable(sp_q)));
   assert_pop_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == STK_POP && sp_q != '0) |=> sp_q == $past(sp_q) - 1'b1);
   assert_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == STK_POP && sp_q == '0) |=> (unf_o && sp_q == '0));
   assert_load_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == STK_LOAD) |=> (sp_q == $past(load_val_i) && !ovf_o && !unf_o));
   assert_flags_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_o && unf_o));
endmodule

// File: rtl/stk_ram.sv
module stk_ram #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 128,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o
);
   generate
      if (DEPTH != (1 << ADDR_W)) begin : g_bad_depth
         $error("stk_ram: depth must be a power of two");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_data_o <= '0;
      else if (rd_en_i) rd_data_o <= mem[rd_addr_i];
   end

   assert_dout_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> $stable(rd_data_o));
   assert_no_rw_clash_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && rd_en_i));
endmodule

// File: rtl/stk_engine.sv
module stk_engine
   import stk_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PTR_W     = 8,
   parameter int RAM_DEPTH = 128,
   parameter int RESET_PTR = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [DATA_W-1:0] din_i,
   input  logic              ptr_load_i,
   input  logic [PTR_W-1:0]  ptr_val_i,
   output logic [DATA_W-1:0] dout_o,
   output logic [PTR_W-1:0]  sp_o,
   output logic              ovf_o,
   output logic              unf_o
);
   localparam int ADDR_W = $clog2(RAM_DEPTH);

   stk_op_e           op;
   logic              wr_en, rd_en;
   logic [ADDR_W-1:0] wr_addr, rd_addr;

   stk_op_decode u_dec (
      .push_i (push_i),
      .pop_i  (pop_i),
      .load_i (ptr_load_i),
      .op_o   (op)
   );

   stk_ptr_ctrl #(
      .PTR_W     (PTR_W),
      .RAM_DEPTH (RAM_DEPTH),
      .RESET_PTR (RESET_PTR)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_i       (op),
      .load_val_i (ptr_val_i),
      .sp_o       (sp_o),
      .ovf_o      (ovf_o),
      .unf_o      (unf_o),
      .wr_en_o    (wr_en),
      .wr_addr_o  (wr_addr),
      .rd_en_o    (rd_en),
      .rd_addr_o  (rd_addr)
   );

   stk_ram #(
      .DATA_W (DATA_W),
      .DEPTH  (RAM_DEPTH)
   ) u_ram (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (din_i),
      .rd_en_i   (rd_en),
      .rd_addr_i (rd_addr),
      .rd_data_o (dout_o)
   );

   assert_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i && !ptr_load_i) |=>
         ($stable(sp_o) && $stable(dout_o) && !ovf_o && !unf_o));
endmodule

// File: tb/tb_stk_engine.sv
`timescale 1ns/1ps
module tb_stk_engine;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       push_i = 1'b0, pop_i = 1'b0, ptr_load_i = 1'b0;
   logic [7:0] din_i = 8'h00, ptr_val_i = 8'h00;
   logic [7:0] dout_o, sp_o;
   logic       ovf_o, unf_o;

   int n_cmp = 0, n_bad = 0;

   logic [7:0] m_mem [128];
   bit         m_ok  [128];
   logic [7:0] m_sp, m_dout;
   bit         m_ovf, m_unf, m_dout_ok;

   always #2 clk = ~clk;

   stk_engine dut (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .din_i(din_i),
      .ptr_load_i(ptr_load_i), .ptr_val_i(ptr_val_i), .dout_o(dout_o),
      .sp_o(sp_o), .ovf_o(ovf_o), .unf_o(unf_o)
   );

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   task automatic cmp(string req, string what, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(bit ps, bit pp, bit ld, logic [7:0] sp);
      if (ld)            return "R6";
      if (ps && pp)      return "R7";
      if (ps)            return (sp >= 8'h7F) ? "R3" : "R2";
      if (pp)            return (sp == 8'h00) ? "R5" : ((sp > 8'h7F) ? "R8" : "R4");
      return "R4";
   endfunction

   // expected next state from the requirements
   task automatic model(bit ps, bit pp, bit ld, logic [7:0] lv, logic [7:0] d);
      m_ovf = 0; m_unf = 0;
      if (ld) m_sp = lv;
      else if (ps && !pp) begin
         if (m_sp >= 8'h7F) m_ovf = 1;
         else begin
            m_sp = m_sp + 8'd1;
            m_mem[m_sp[6:0]] = d;
            m_ok[m_sp[6:0]]  = 1;
         end
      end else if (pp && !ps) begin
         if (m_sp == 8'h00) m_unf = 1;
         else begin
            m_dout    = m_mem[m_sp[6:0]];
            m_dout_ok = m_ok[m_sp[6:0]];
            m_sp      = m_sp - 8'd1;
         end
      end
   endtask

   task automatic step(bit ps, bit pp, bit ld, logic [7:0] lv, logic [7:0] d);
      string r;
      r = req_of(ps, pp, ld, m_sp);
      push_i = ps; pop_i = pp; ptr_load_i = ld; ptr_val_i = lv; din_i = d;
      @(posedge clk);
      model(ps, pp, ld, lv, d);
      @(negedge clk);
      push_i = 0; pop_i = 0; ptr_load_i = 0;
      cmp(r, "sp", sp_o, m_sp);
      cmp(r, "ovf", {7'd0, ovf_o}, {7'd0, m_ovf});
      cmp(r, "unf", {7'd0, unf_o}, {7'd0, m_unf});
      if (m_dout_ok) cmp(r, "dout", dout_o, m_dout);
   endtask

   initial begin
      for (int i = 0; i < 128; i++) m_ok[i] = 0;
      m_sp = 8'h07; m_dout = 8'h00; m_dout_ok = 1; m_ovf = 0; m_unf = 0;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1 reset state
      cmp("R1", "sp", sp_o, 8'h07);
      cmp("R1", "ovf", {7'd0, ovf_o}, 8'h00);
      cmp("R1", "unf", {7'd0, unf_o}, 8'h00);
      cmp("R1", "dout", dout_o, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 first push lands at 08h, popped straight back
      step(1, 0, 0, 0, 8'hA5);
      cmp("R2", "first push sp", sp_o, 8'h08);
      step(0, 1, 0, 0, 0);
      cmp("R4", "pop of 08h", dout_o, 8'hA5);
      // fill the RAM 01h..7Fh
      step(0, 0, 1, 8'h00, 0);
      for (int i = 1; i < 128; i++) step(1, 0, 0, 0, 8'(i * 37 + 11));
      cmp("R2", "full sp", sp_o, 8'h7F);
      // R3 overflow at top
      step(1, 0, 0, 0, 8'hEE);
      step(1, 0, 0, 0, 8'hDD);
      // R7 simultaneous push and pop
      step(1, 1, 0, 0, 8'h33);
      // R6 load wins over push; byte not stored
      step(1, 0, 1, 8'h10, 8'h99);
      step(0, 1, 0, 0, 0);
      cmp("R6", "byte at 10h kept", dout_o, 8'(16 * 37 + 11));
      // R8 pointer above RAM top
      step(0, 0, 1, 8'h85, 0);
      step(0, 1, 0, 0, 0);
      cmp("R8", "pop at 85h", dout_o, 8'(5 * 37 + 11));
      // R5 underflow
      step(0, 0, 1, 8'h01, 0);
      step(0, 1, 0, 0, 0);
      step(0, 1, 0, 0, 0);
      step(0, 1, 0, 0, 0);
      // pop entire stack back down
      step(0, 0, 1, 8'h7F, 0);
      for (int i = 0; i < 127; i++) step(0, 1, 0, 0, 0);
      // constrained random
      for (int i = 0; i < 4000; i++) begin
         int k;
         k = $urandom_range(0, 99);
         if (k < 5)       step($urandom_range(0, 1), $urandom_range(0, 1), 1,
                               8'($urandom_range(0, 127)), 8'($urandom));
         else if (k < 45) step(1, 0, 0, 0, 8'($urandom));
         else if (k < 85) step(0, 1, 0, 0, 0);
         else if (k < 92) step(1, 1, 0, 0, 8'($urandom));
         else             step(0, 0, 0, 0, 8'($urandom));
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule